// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Controller

This block sits beside a program sequencer and executes counted loops with no decrement, compare or branch instructions in the kernel. A setup command carries an iteration count, the address of the first kernel instruction and the address of the last one. Once a loop is accepted, the controller watches the fetch program counter. When fetch reaches the last kernel address and more iterations remain, it redirects fetch back to the first kernel address and decrements the count in that same cycle. The last pass continues straight to the address after the kernel.

While a loop runs, the controller holds a registered interrupt mask high and reports any branch fetched from inside the kernel. A setup whose kernel is longer than `MAX_KERNEL` instructions, or whose last address lies below its first, is refused. A setup that arrives while a loop is already running is ignored and reported as a nesting error. Only one loop level is supported.

Top module: `hwloop_ctrl`

## Requirements
- R1: An accepted setup (`setup_valid_i` high, no loop running, valid length, count of 1 or more) makes `loop_active_o` high and `count_o` equal to the setup count from the next cycle on. During the setup cycle there is no redirect.
- R2: While a loop runs and more than one iteration remains, a valid fetch of the last kernel address asserts `redirect_o` in that same cycle with `redirect_pc_o` equal to the first kernel address. `count_o` is one lower from the next cycle on. No other fetch causes a redirect.
- R3: On the last iteration, a valid fetch of the last kernel address asserts `redirect_o` in that same cycle with `redirect_pc_o` equal to the last address plus one. From the next cycle on, `loop_active_o` is low and `count_o` is 0.
- R4: An accepted setup with a count of 0 asserts `redirect_o` in the setup cycle with `redirect_pc_o` equal to the last address plus one. It starts no loop.
- R5: `irq_mask_o` is registered. It is high from the cycle after an accepted setup with a nonzero count, and it stays high through the cycle after `loop_active_o` falls. It is low in the cycle after that, unless a new loop has started.
- R6: A fetch with `fetch_valid_i` and `fetch_is_branch_i` high, made while a loop runs at an address from first to last kernel address inclusive, makes `branch_err_o` high for exactly the next cycle. A branch fetched outside the kernel, or while no loop runs, leaves it low.
- R7: A setup whose kernel length (last minus first plus one) exceeds `MAX_KERNEL` (default 16), or whose last address is below its first, is rejected. `length_err_o` is high for the next cycle, no loop starts and no redirect is issued. A length of exactly `MAX_KERNEL` is accepted.
- R8: A setup made while a loop runs is ignored. `nest_err_o` is high for the next cycle, and the count and the kernel addresses of the running loop do not change.
- R9: After reset, all outputs are low and `count_o` is 0.
- R10: A loop of N iterations over an L-instruction kernel takes exactly N*L kernel fetches, with no fetch cycles spent on loop control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| setup_valid_i | input | 1 | Loop setup request |
| setup_count_i | input | CNT_W | Iteration count |
| setup_start_i | input | PC_W | First kernel address |
| setup_end_i | input | PC_W | Last kernel address |
| fetch_valid_i | input | 1 | A fetch happens this cycle |
| fetch_pc_i | input | PC_W | Fetch address |
| fetch_is_branch_i | input | 1 | The fetched instruction is a branch |
| redirect_o | output | 1 | Override the next fetch address |
| redirect_pc_o | output | PC_W | Next fetch address when redirecting |
| loop_active_o | output | 1 | A loop is running |
| count_o | output | CNT_W | Iterations remaining |
| irq_mask_o | output | 1 | Registered interrupt mask |
| branch_err_o | output | 1 | Branch fetched inside kernel (pulse) |
| nest_err_o | output | 1 | Setup made while a loop runs (pulse) |
| length_err_o | output | 1 | Setup rejected for kernel length (pulse) |

## Verification
The bench sweeps iteration counts 0 to 4 against kernel lengths of 1, 2, 3 and `MAX_KERNEL`. It models a sequencer that follows the redirects and counts kernel fetches. An off-by-one in the remaining-count test would show up here as one pass too many or too few, and a late redirect would show up as an extra fetch past the last address. It checks the one-cycle interrupt tail after exit, which a mask driven only from the loop state would drop too early. It also checks that a zero count skips the kernel in the setup cycle rather than running it once. It tests rejection exactly at the length limit and one past it, and a reversed address range. It fires branches inside the kernel, outside it while the loop runs, and with no loop running, and it issues a setup in mid-loop to confirm the remaining count does not change.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;
  typedef enum logic {
    LOOP_IDLE = 1'b0,
    LOOP_RUN  = 1'b1
  } loop_state_e;
endpackage

// File: rtl/hwloop_len_chk.sv
module hwloop_len_chk #(
  parameter int unsigned PC_W       = 16,
  parameter int unsigned MAX_KERNEL = 16
) (
  input  logic [PC_W-1:0] start_i,
  input  logic [PC_W-1:0] end_i,
  output logic            len_ok_o
);
  logic [PC_W-1:0] span;
  always_comb begin
    span     = end_i - start_i;
    len_ok_o = (end_i >= start_i) && (32'(span) < MAX_KERNEL);
  end
endmodule

// File: rtl/hwloop_seq.sv
module hwloop_seq
  import hwloop_pkg::*;
#(
  parameter int unsigned PC_W  = 16,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             setup_go_i,
  input  logic [CNT_W-1:0] setup_count_i,
  input  logic [PC_W-1:0]  setup_start_i,
  input  logic [PC_W-1:0]  setup_end_i,
  input  logic             fetch_valid_i,
  input  logic [PC_W-1:0]  fetch_pc_i,
  output logic             active_o,
  output logic             active_d_o,
  output logic             in_kernel_o,
  output logic [CNT_W-1:0] count_o,
  output logic             redirect_o,
  output logic [PC_W-1:0]  redirect_pc_o
);
  loop_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PC_W-1:0]  start_q, end_q;
  logic             at_end, load;

  assign at_end = (state_q == LOOP_RUN) && fetch_valid_i && (fetch_pc_i == end_q);
  assign load   = (state_q == LOOP_IDLE) && setup_go_i && (setup_count_i != '0);

  always_comb begin
    state_d       = state_q;
    cnt_d         = cnt_q;
    redirect_o    = 1'b0;
    redirect_pc_o = '0;
    if (state_q == LOOP_RUN) begin
      if (at_end) begin
        redirect_o = 1'b1;
        if (cnt_q > CNT_W'(1)) begin
          redirect_pc_o = start_q;
          cnt_d         = cnt_q - CNT_W'(1);
        end else begin
          redirect_pc_o = end_q + PC_W'(1);
          cnt_d         = '0;
          state_d       = LOOP_IDLE;
        end
      end
    end else if (setup_go_i) begin
      if (setup_count_i == '0) begin
        // zero count: skip the kernel
        redirect_o    = 1'b1;
        redirect_pc_o = setup_end_i + PC_W'(1);
      end else begin
        state_d = LOOP_RUN;
        cnt_d   = setup_count_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= LOOP_IDLE;
      cnt_q   <= '0;
      start_q <= '0;
      end_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (load) begin
        start_q <= setup_start_i;
        end_q   <= setup_end_i;
      end
    end
  end

  assign active_o    = (state_q == LOOP_RUN);
  assign active_d_o  = (state_d == LOOP_RUN);
  assign in_kernel_o = (fetch_pc_i >= start_q) && (fetch_pc_i <= end_q);
  assign count_o     = cnt_q;

  AST_RUN_CNT_NZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> (cnt_q != '0)); // R1
  AST_REDIR_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> (at_end || (setup_go_i && !active_o))); // R2
  AST_CNT_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_end && cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)) && active_o); // R2
  AST_LAST_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_end && cnt_q == CNT_W'(1)) |=> !active_o && (cnt_q == '0)); // R3
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |=> $stable(start_q) && $stable(end_q)); // R8
endmodule

// File: rtl/hwloop_guard.sv
module hwloop_guard #(
  parameter int unsigned PC_W = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic active_d_i,
  input  logic in_kernel_i,
  input  logic fetch_valid_i,
  input  logic fetch_is_branch_i,
  input  logic setup_valid_i,
  input  logic len_ok_i,
  output logic irq_mask_o,
  output logic branch_err_o,
  output logic nest_err_o,
  output logic length_err_o
);
  logic mask_q, br_q, nest_q, len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= 1'b0;
      br_q   <= 1'b0;
      nest_q <= 1'b0;
      len_q  <= 1'b0;
    end else begin
      // held one extra cycle past loop exit
      mask_q <= active_d_i | active_i;
      br_q   <= active_i & fetch_valid_i & fetch_is_branch_i & in_kernel_i;
      nest_q <= active_i & setup_valid_i;
      len_q  <= ~active_i & setup_valid_i & ~len_ok_i;
    end
  end

  assign irq_mask_o   = mask_q;
  assign branch_err_o = br_q;
  assign nest_err_o   = nest_q;
  assign length_err_o = len_q;

  AST_MASK_COVERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i |-> irq_mask_o); // R5
  AST_MASK_TAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_i) |-> irq_mask_o); // R5
  AST_BR_ONLY_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> !branch_err_o); // R6
  AST_NEST_ONLY_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> !nest_err_o); // R8
endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl #(
  parameter int unsigned PC_W       = 16,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned MAX_KERNEL = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             setup_valid_i,
  input  logic [CNT_W-1:0] setup_count_i,
  input  logic [PC_W-1:0]  setup_start_i,
  input  logic [PC_W-1:0]  setup_end_i,
  input  logic             fetch_valid_i,
  input  logic [PC_W-1:0]  fetch_pc_i,
  input  logic             fetch_is_branch_i,
  output logic             redirect_o,
  output logic [PC_W-1:0]  redirect_pc_o,
  output logic             loop_active_o,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_mask_o,
  output logic             branch_err_o,
  output logic             nest_err_o,
  output logic             length_err_o
);
  logic len_ok, setup_go, active, active_d, in_kernel;

  hwloop_len_chk #(.PC_W(PC_W), .MAX_KERNEL(MAX_KERNEL)) u_len (
    .start_i  (setup_start_i),
    .end_i    (setup_end_i),
    .len_ok_o (len_ok)
  );

  assign setup_go = setup_valid_i & ~active & len_ok;

  hwloop_seq #(.PC_W(PC_W), .CNT_W(CNT_W)) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .setup_go_i    (setup_go),
    .setup_count_i (setup_count_i),
    .setup_start_i (setup_start_i),
    .setup_end_i   (setup_end_i),
    .fetch_valid_i (fetch_valid_i),
    .fetch_pc_i    (fetch_pc_i),
    .active_o      (active),
    .active_d_o    (active_d),
    .in_kernel_o   (in_kernel),
    .count_o       (count_o),
    .redirect_o    (redirect_o),
    .redirect_pc_o (redirect_pc_o)
  );

  hwloop_guard #(.PC_W(PC_W)) u_guard (
    .clk_i             (clk_i),
    .rst_ni            (rst_ni),
    .active_i          (active),
    .active_d_i        (active_d),
    .in_kernel_i       (in_kernel),
    .fetch_valid_i     (fetch_valid_i),
    .fetch_is_branch_i (fetch_is_branch_i),
    .setup_valid_i     (setup_valid_i),
    .len_ok_i          (len_ok),
    .irq_mask_o        (irq_mask_o),
    .branch_err_o      (branch_err_o),
    .nest_err_o        (nest_err_o),
    .length_err_o      (length_err_o)
  );

  assign loop_active_o = active;

  AST_LEN_NO_REDIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (setup_valid_i && !len_ok && !active) |-> !redirect_o); // R7
  AST_LEN_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (setup_valid_i && !len_ok && !active) |=> !loop_active_o); // R7
  AST_NEST_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && setup_valid_i && !redirect_o) |=> $stable(count_o)); // R8
endmodule

// File: tb/sim_hwloop_ctrl.sv
`timescale 1ns/1ps
module sim_hwloop_ctrl;
  localparam int MAXK = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic setup_valid = 0, fetch_valid = 0, fetch_br = 0;
  logic [15:0] setup_count = 0, setup_start = 0, setup_end = 0, fetch_pc = 0;
  logic redirect, active, irq_mask, br_err, nest_err, len_err;
  logic [15:0] redirect_pc, count;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  hwloop_ctrl #(.PC_W(16), .CNT_W(16), .MAX_KERNEL(MAXK)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .setup_valid_i(setup_valid), .setup_count_i(setup_count),
    .setup_start_i(setup_start), .setup_end_i(setup_end), .fetch_valid_i(fetch_valid),
    .fetch_pc_i(fetch_pc), .fetch_is_branch_i(fetch_br), .redirect_o(redirect),
    .redirect_pc_o(redirect_pc), .loop_active_o(active), .count_o(count),
    .irq_mask_o(irq_mask), .branch_err_o(br_err), .nest_err_o(nest_err), .length_err_o(len_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; setup_valid = 0; fetch_valid = 0; fetch_br = 0;
    @(negedge clk); rst_n = 1;
  endtask

  task automatic run_loop(input int n, input int st, input int len);
    logic [15:0] en;
    int fetches = 0, rem, pc;
    bit done = 0;
    en = 16'(st + len - 1);
    @(negedge clk);
    setup_valid = 1; setup_count = 16'(n); setup_start = 16'(st); setup_end = en; fetch_valid = 0;
    #1;
    if (n == 0) chk(redirect && redirect_pc == en + 16'd1, "R4 skip redirect", int'(redirect_pc), int'(en) + 1);
    else chk(!redirect, "R1 no redirect at setup", int'(redirect), 0);
    @(negedge clk); setup_valid = 0;
    chk(active == (n != 0), "R1 active after setup", int'(active), int'(n != 0));
    chk(irq_mask == (n != 0), "R5 mask after setup", int'(irq_mask), int'(n != 0));
    if (n == 0) return;
    chk(count == 16'(n), "R1 count loaded", int'(count), n);
    rem = n; pc = st;
    for (int g = 0; g < n * len + 4 && !done; g++) begin
      chk(count == 16'(rem), "R2 remaining count", int'(count), rem);
      fetch_valid = 1; fetch_pc = 16'(pc); #1;
      fetches++;
      if (pc == int'(en)) begin
        if (rem > 1) begin
          chk(redirect && redirect_pc == 16'(st), "R2 loop back", int'(redirect_pc), st);
          rem--; pc = st;
        end else begin
          chk(redirect && redirect_pc == en + 16'd1, "R3 exit address", int'(redirect_pc), int'(en) + 1);
          done = 1;
        end
      end else begin
        if (redirect) chk(0, "R2 spurious redirect", int'(redirect_pc), 0);
        pc++;
      end
      if (!done) @(negedge clk);
    end
    @(negedge clk); fetch_valid = 0;
    chk(!active && count == 0, "R3 inactive after last pass", int'(active), 0);
    chk(irq_mask, "R5 mask tail", int'(irq_mask), 1);
    chk(fetches == n * len, "R10 fetch count", fetches, n * len);
    @(negedge clk);
    chk(!irq_mask, "R5 mask released", int'(irq_mask), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!redirect && !active && !irq_mask && !br_err && !nest_err && !len_err && count == 0,
        "R9 reset state", int'(active), 0);
    @(negedge clk); rst_n = 1;

    // sweep counts and kernel lengths
    for (int n = 0; n <= 4; n++)
      for (int li = 0; li < 4; li++) begin
        int len;
        len = (li == 3) ? MAXK : li + 1;
        run_loop(n, 'h100 + 37 * n + 5 * li, len);
      end

    // R7: length limit + 1, and reversed range with zero count
    @(negedge clk);
    setup_valid = 1; setup_count = 3; setup_start = 16'h200; setup_end = 16'h200 + 16'(MAXK);
    #1; chk(!redirect, "R7 no redirect on long kernel", int'(redirect), 0);
    @(negedge clk); setup_valid = 0;
    chk(len_err && !active && !irq_mask, "R7 long kernel rejected", int'(len_err), 1);
    setup_valid = 1; setup_count = 0; setup_start = 16'h80; setup_end = 16'h7F;
    #1; chk(!redirect, "R7 no skip on reversed range", int'(redirect), 0);
    @(negedge clk); setup_valid = 0;
    chk(len_err && !active, "R7 reversed range rejected", int'(len_err), 1);
    @(negedge clk);
    chk(!len_err, "R7 error is a pulse", int'(len_err), 0);

    // R6 / R8: loop of 2 over 0x40..0x42
    do_reset();
    setup_valid = 1; setup_count = 2; setup_start = 16'h40; setup_end = 16'h42;
    @(negedge clk); setup_valid = 0;
    fetch_valid = 1; fetch_pc = 16'h40; fetch_br = 0;
    @(negedge clk); fetch_pc = 16'h41; fetch_br = 1;
    @(negedge clk); fetch_br = 0;
    chk(br_err, "R6 branch in kernel flagged", int'(br_err), 1);
    fetch_pc = 16'h42;
    @(negedge clk);
    chk(!br_err, "R6 branch error single pulse", int'(br_err), 0);
    chk(count == 1, "R2 count after loop back", int'(count), 1);
    fetch_pc = 16'h50; fetch_br = 1;
    @(negedge clk); fetch_br = 0; fetch_valid = 0;
    chk(!br_err, "R6 branch outside kernel ignored", int'(br_err), 0);
    setup_valid = 1; setup_count = 9; setup_start = 16'h10; setup_end = 16'h12;
    @(negedge clk); setup_valid = 0;
    chk(nest_err, "R8 nested setup flagged", int'(nest_err), 1);
    chk(count == 1 && active, "R8 count unchanged", int'(count), 1);
    fetch_valid = 1; fetch_pc = 16'h40;
    @(negedge clk); fetch_pc = 16'h41;
    @(negedge clk); fetch_pc = 16'h42; #1;
    chk(redirect && redirect_pc == 16'h43, "R8 old kernel end kept", int'(redirect_pc), 'h43);
    @(negedge clk);
    chk(!active, "R3 loop done", int'(active), 0);
    fetch_pc = 16'h41; fetch_br = 1;
    @(negedge clk); fetch_br = 0; fetch_valid = 0;
    chk(!br_err, "R6 branch while idle ignored", int'(br_err), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule